// File: doc/BRIEF.md
# Time-Slot Gated HDLC Transmitter

This block turns bytes written into a small transmit queue into a serial HDLC bit stream. The stream is placed into a framed time-division multiplex line with 24 channel slots of eight bits plus one framing bit per frame. A frame counter outside the block reports the current line position as a framing-bit strobe and a slot index. A programmable slot mask selects which channel slots carry this block's bits. One bit leaves the block for each enabled bit time, and the transmitter holds its state through every other bit time.

In packet mode every frame is wrapped in opening and closing flags. A 16-bit CRC is appended, and a zero is stuffed after any run of five ones in the payload and CRC. Between frames the line carries repeated flags or a programmable idle byte. A transparent mode sends the queued bytes unchanged, with no framing. A continuous mode loops over the queue contents instead of consuming them. If the queue runs dry in the middle of a frame, the frame is aborted and an underrun pulse is raised.

Top module: `hdlc_slot_tx`

## Requirements
- R1: An enabled position is one where `fbit` is 0 and `slot_mask[slot_idx]` is 1. `tx_valid` is high in the cycle after an enabled position and low in every other cycle. The bit stream advances only on enabled positions, so masked slots and the framing bit do not disturb its continuity.
- R2: In packet mode (`raw_mode`=0) a queued frame starts with the flag 0x7E. Its bytes follow in write order, each sent LSB first, and the frame ends with the flag 0x7E after its CRC. The byte written with `wr_last`=1 is the last byte of its frame.
- R3: In packet mode, after five consecutive 1 bits in the payload or CRC, the transmitter inserts one 0 bit before the next bit.
- R4: The CRC is the reflected CRC-16 with polynomial x^16+x^12+x^5+1 (0x8408 in reflected form), preset to 0xFFFF and computed over the payload bits. The transmitter complements it and sends the low byte first, each byte LSB first.
- R5: With no frame pending in packet mode, the line carries whole bytes of fill, sent LSB first. The fill is 0x7E when `fill_idle`=0 and `idle_code` when `fill_idle`=1.
- R6: The queue holds up to DEPTH (default 64) bytes, and `fifo_full` is 1 while it holds DEPTH bytes. A write while `fifo_full` is 1 is ignored, and the dropped byte never appears on the line.
- R7: In transparent mode (`raw_mode`=1) bytes are sent LSB first with no flags, no CRC and no stuffing, and `wr_last` has no effect. When no byte is queued, `idle_code` bytes are sent.
- R8: With `cont_en`=1 the queued bytes are sent in write order and then repeated from the first one, without leaving the queue.
- R9: In packet mode, if the next payload byte is missing when it is needed, the transmitter sends eight 1 bits as an abort. `underrun` is high for one cycle, in the same cycle as the first abort bit on `tx_bit`, and fill follows the abort.
- R10: After reset `tx_valid`, `underrun` and `fifo_full` are 0, and the first enabled bit starts a byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one line bit time |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the byte queue |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks the written byte as the frame's last |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| raw_mode | input | 1 | 1 selects transparent mode |
| cont_en | input | 1 | 1 replays the queue contents repeatedly |
| fill_idle | input | 1 | Interframe fill: 0 flags, 1 idle byte |
| idle_code | input | 8 | Programmable idle byte |
| slot_mask | input | NSLOT | One enable bit per channel slot |
| fbit | input | 1 | Current position is the framing bit |
| slot_idx | input | SLOT_W | Current channel slot number |
| tx_bit | output | 1 | Serial data, 1 when not valid |
| tx_valid | output | 1 | `tx_bit` carries a transmitted bit |
| underrun | output | 1 | One-cycle pulse at the start of an abort |

## Verification
The output register sits one cycle after the position inputs, so `tx_valid` and `tx_bit` for a bit time are due one cycle after the enabled position. The bench samples on the falling edge and, in the gating scenario, compares each sample with the enable it computed from the inputs it drove one cycle earlier. A written byte reaches the staging register two cycles after the write. Each scenario therefore loads the queue with every slot masked and waits several cycles before it opens the slots, which fixes the first bit of the stream. The `underrun` pulse is checked against the bit stream it accompanies, within the same collection window.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    K_FILL,
    K_OPEN,
    K_DATA,
    K_CRCL,
    K_CRCH,
    K_CLOSE,
    K_ABORT,
    K_RAW
  } byte_kind_e;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'hFF;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [2:0]  RUN_LIMIT  = 3'd5;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = c >> 1;
    if (c[0] ^ b) s = s ^ CRC_POLY_R;
    return s;
  endfunction

endpackage

// File: rtl/hdlc_slot_gate.sv
module hdlc_slot_gate #(
  parameter int NSLOT  = 24,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              fbit,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [NSLOT-1:0]  slot_mask,
  output logic              en
);

  logic [NSLOT-1:0] hit;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hit[g] = slot_mask[g] && (slot_idx == SLOT_W'(g));
  end

  assign en = !fbit && (|hit);

endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          cont_en,
  input  logic          take,
  output logic          full,
  output logic          head_valid,
  output logic [DW-1:0] head_data,
  output logic          head_last
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW:0]   mem [DEPTH];
  logic [DW:0]   head_q;
  logic [AW-1:0] wr_ptr, rd_ptr, fptr, rd_addr;
  logic [CW-1:0] mem_cnt, occ;
  logic          head_v_q;
  logic          wr_ok, fetch, drop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (occ == CW'(DEPTH));
  assign wr_ok   = wr_en && !full;
  assign fetch   = !head_v_q && (mem_cnt != '0);
  assign drop    = take && !cont_en;
  assign rd_addr = !cont_en ? rd_ptr : ((fptr == wr_ptr) ? rd_ptr : fptr);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (fetch) head_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fptr     <= '0;
      mem_cnt  <= '0;
      occ      <= '0;
      head_v_q <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= nxt(wr_ptr);
      if (take) head_v_q <= 1'b0;
      else if (fetch) head_v_q <= 1'b1;
      if (!cont_en) begin
        if (fetch) begin
          rd_ptr <= nxt(rd_ptr);
          fptr   <= nxt(rd_ptr);
        end else begin
          fptr   <= rd_ptr;
        end
        mem_cnt <= mem_cnt + CW'(wr_ok) - CW'(fetch);
      end else begin
        if (fetch) fptr <= nxt(rd_addr);
        mem_cnt <= mem_cnt + CW'(wr_ok);
      end
      occ <= occ + CW'(wr_ok) - CW'(drop);
    end
  end

  assign head_valid = head_v_q;
  assign head_data  = head_q[DW-1:0];
  assign head_last  = head_q[DW];

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= CW'(DEPTH)); // R6
  AST_TAKE_NEEDS_HEAD: assert property (@(posedge clk) disable iff (rst) take |-> head_v_q); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (full && !drop) |=> full); // R6

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       raw_mode,
  input  logic       fill_idle,
  input  logic [7:0] idle_code,
  input  logic       head_valid,
  input  logic [7:0] head_data,
  input  logic       head_last,
  output logic       take,
  output logic       bit_out,
  output logic       abort_start
);

  byte_kind_e  kind_q, sel_kind, cur_kind;
  logic [7:0]  sh_q, sel_byte, fill_byte;
  logic [2:0]  bc_q, ones_q;
  logic [15:0] crc_q;
  logic        last_q, sel_take;
  logic        stuff_now, start, cur_bit, stuffed;

  always_comb begin
    fill_byte = fill_idle ? idle_code : FLAG_BYTE;
    sel_kind  = K_FILL;
    sel_byte  = fill_byte;
    sel_take  = 1'b0;
    if (raw_mode) begin
      if (head_valid) begin
        sel_kind = K_RAW;
        sel_byte = head_data;
        sel_take = 1'b1;
      end else begin
        sel_byte = idle_code;
      end
    end else begin
      case (kind_q)
        K_OPEN, K_DATA: begin
          if (kind_q == K_DATA && last_q) begin
            sel_kind = K_CRCL;
            sel_byte = ~crc_q[7:0];
          end else if (head_valid) begin
            sel_kind = K_DATA;
            sel_byte = head_data;
            sel_take = 1'b1;
          end else begin
            sel_kind = K_ABORT;
            sel_byte = ABORT_BYTE;
          end
        end
        K_CRCL: begin
          sel_kind = K_CRCH;
          sel_byte = ~crc_q[15:8];
        end
        K_CRCH: begin
          sel_kind = K_CLOSE;
          sel_byte = FLAG_BYTE;
        end
        default: begin
          if (head_valid) begin
            sel_kind = K_OPEN;
            sel_byte = FLAG_BYTE;
          end
        end
      endcase
    end
  end

  assign stuff_now   = (ones_q == RUN_LIMIT);
  assign start       = (bc_q == 3'd0) && !stuff_now;
  assign cur_kind    = start ? sel_kind : kind_q;
  assign cur_bit     = stuff_now ? 1'b0 : (start ? sel_byte[0] : sh_q[0]);
  assign stuffed     = (cur_kind == K_DATA) || (cur_kind == K_CRCL) || (cur_kind == K_CRCH);
  assign take        = step && start && sel_take;
  assign abort_start = step && start && (sel_kind == K_ABORT);
  assign bit_out     = cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= K_FILL;
      sh_q   <= '0;
      bc_q   <= '0;
      ones_q <= '0;
      crc_q  <= CRC_PRESET;
      last_q <= 1'b0;
    end else if (step) begin
      if (stuff_now) begin
        ones_q <= '0;
      end else begin
        if (start) begin
          kind_q <= sel_kind;
          sh_q   <= {1'b0, sel_byte[7:1]};
          bc_q   <= 3'd1;
          if (sel_kind == K_DATA) last_q <= head_last;
          if (sel_kind == K_OPEN) crc_q <= CRC_PRESET;
        end else begin
          sh_q <= sh_q >> 1;
          bc_q <= bc_q + 3'd1;
        end
        ones_q <= (stuffed && cur_bit) ? ones_q + 3'd1 : 3'd0;
        if (cur_kind == K_DATA) crc_q <= crc_step(crc_q, cur_bit);
      end
    end
  end

  AST_ONES_LIMIT: assert property (@(posedge clk) disable iff (rst) ones_q <= RUN_LIMIT); // R3
  AST_STUFF_CLEARS: assert property (@(posedge clk) disable iff (rst) (step && ones_q == RUN_LIMIT) |=> (ones_q == 3'd0)); // R3

endmodule

// File: rtl/hdlc_slot_tx.sv
module hdlc_slot_tx #(
  parameter int NSLOT  = 24,
  parameter int DEPTH  = 64,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              wr_last,
  output logic              fifo_full,
  input  logic              raw_mode,
  input  logic              cont_en,
  input  logic              fill_idle,
  input  logic [7:0]        idle_code,
  input  logic [NSLOT-1:0]  slot_mask,
  input  logic              fbit,
  input  logic [SLOT_W-1:0] slot_idx,
  output logic              tx_bit,
  output logic              tx_valid,
  output logic              underrun
);

  logic       en, take, eng_bit, abort_start;
  logic       head_valid, head_last;
  logic [7:0] head_data;

  hdlc_slot_gate #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) i_gate (
    .fbit      (fbit),
    .slot_idx  (slot_idx),
    .slot_mask (slot_mask),
    .en        (en)
  );

  hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(8)) i_fifo (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_last    (wr_last),
    .cont_en    (cont_en),
    .take       (take),
    .full       (fifo_full),
    .head_valid (head_valid),
    .head_data  (head_data),
    .head_last  (head_last)
  );

  hdlc_tx_engine i_engine (
    .clk         (clk),
    .rst         (rst),
    .step        (en),
    .raw_mode    (raw_mode),
    .fill_idle   (fill_idle),
    .idle_code   (idle_code),
    .head_valid  (head_valid),
    .head_data   (head_data),
    .head_last   (head_last),
    .take        (take),
    .bit_out     (eng_bit),
    .abort_start (abort_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_bit   <= 1'b1;
      underrun <= 1'b0;
    end else begin
      tx_valid <= en;
      tx_bit   <= en ? eng_bit : 1'b1;
      underrun <= abort_start;
    end
  end

  AST_FBIT_SILENT: assert property (@(posedge clk) disable iff (rst) tx_valid |-> $past(!fbit)); // R1
  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (rst) underrun |=> !underrun); // R9
  AST_UNDERRUN_WITH_BIT: assert property (@(posedge clk) disable iff (rst) underrun |-> (tx_valid && tx_bit)); // R9

endmodule

// File: tb/test_hdlc_slot_tx.sv
`timescale 1ns/1ps
module test_hdlc_slot_tx;

  localparam int NSLOT = 24;
  localparam int DEPTH = 64;
  localparam int SW    = $clog2(NSLOT);

  logic             clk = 1'b0;
  logic             rst;
  logic             wr_en, wr_last, raw_mode, cont_en, fill_idle, fbit;
  logic [7:0]       wr_data, idle_code;
  logic [NSLOT-1:0] slot_mask;
  logic [SW-1:0]    slot_idx;
  logic             fifo_full, tx_bit, tx_valid, underrun;

  int checks = 0;
  int errs   = 0;
  int ucnt   = 0;
  bit got_q[$];
  bit exp_q[$];
  int sone;

  always #5 clk = ~clk;

  hdlc_slot_tx #(.NSLOT(NSLOT), .DEPTH(DEPTH)) i_hdlc_slot_tx (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .fifo_full(fifo_full), .raw_mode(raw_mode), .cont_en(cont_en),
    .fill_idle(fill_idle), .idle_code(idle_code), .slot_mask(slot_mask),
    .fbit(fbit), .slot_idx(slot_idx), .tx_bit(tx_bit), .tx_valid(tx_valid),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit raw, input bit cont, input bit fidle, input logic [7:0] idle);
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; wr_last = 1'b0;
    raw_mode = raw; cont_en = cont; fill_idle = fidle; idle_code = idle;
    slot_mask = '0; fbit = 1'b0; slot_idx = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d, input bit last);
    wr_en = 1'b1; wr_data = d; wr_last = last;
    @(negedge clk);
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic collect(input int n);
    int guard = 0;
    got_q.delete();
    ucnt = 0;
    while (got_q.size() < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (tx_valid) got_q.push_back(tx_bit);
      if (underrun) ucnt++;
    end
  endtask

  task automatic cmp_range(input string req, input string what, input int lo, input int hi);
    int bad = -1;
    for (int i = lo; i <= hi; i++) begin
      if (bad < 0 && (i >= got_q.size() || i >= exp_q.size() || got_q[i] != exp_q[i])) bad = i;
    end
    if (bad < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, $sformatf("%s bit %0d", what, bad),
               (bad < got_q.size()) ? 32'(got_q[bad]) : 32'hDEAD,
               (bad < exp_q.size()) ? 32'(exp_q[bad]) : 32'hDEAD);
  endtask

  task automatic push_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic push_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      sone = b[i] ? sone + 1 : 0;
      if (sone == 5) begin
        exp_q.push_back(1'b0);
        sone = 0;
      end
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic t_reset();
    apply_reset(1'b0, 1'b0, 1'b0, 8'h00);
    check(tx_valid == 1'b0, "R10", "tx_valid after reset", 32'(tx_valid), 0);
    check(underrun == 1'b0, "R10", "underrun after reset", 32'(underrun), 0);
    check(fifo_full == 1'b0, "R10", "fifo_full after reset", 32'(fifo_full), 0);
  endtask

  task automatic t_fill(input bit fidle, input logic [7:0] idle);
    apply_reset(1'b0, 1'b0, fidle, idle);
    exp_q.delete();
    for (int k = 0; k < 3; k++) push_raw(fidle ? idle : 8'h7E);
    slot_mask = '1;
    collect(24);
    cmp_range("R5", fidle ? "idle fill" : "flag fill", 0, 23);
  endtask

  task automatic t_frame(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    int n;
    apply_reset(1'b0, 1'b0, 1'b0, 8'h00);
    exp_q.delete();
    push_raw(8'h7E);
    sone = 0;
    c = crc_byte(c, d0); push_stuffed(d0);
    c = crc_byte(c, d1); push_stuffed(d1);
    c = crc_byte(c, d2); push_stuffed(d2);
    fcs = ~c;
    push_stuffed(fcs[7:0]);
    push_stuffed(fcs[15:8]);
    push_raw(8'h7E);
    push_raw(8'h7E);
    n = exp_q.size();
    write_byte(d0, 1'b0);
    write_byte(d1, 1'b0);
    write_byte(d2, 1'b1);
    repeat (4) @(negedge clk);
    slot_mask = '1;
    collect(n);
    cmp_range("R2", "opening flag", 0, 7);
    // R3: first byte is 0xFF, so bits 8..12 are ones and bit 13 is the stuffed zero
    check(got_q.size() > 14 && got_q[13] == 1'b0 && got_q[14] == 1'b1, "R3",
          "stuffed zero after five ones", got_q.size() > 13 ? 32'(got_q[13]) : 32'hDEAD, 0);
    cmp_range("R4", "payload and CRC stream", 8, n - 17);
    cmp_range("R2", "closing flag and fill", n - 16, n - 1);
  endtask

  task automatic t_underrun();
    apply_reset(1'b0, 1'b0, 1'b0, 8'h00);
    exp_q.delete();
    push_raw(8'h7E);
    sone = 0;
    push_stuffed(8'h12);
    push_stuffed(8'h34);
    push_raw(8'hFF);
    push_raw(8'h7E);
    write_byte(8'h12, 1'b0);
    write_byte(8'h34, 1'b0);
    repeat (4) @(negedge clk);
    slot_mask = '1;
    collect(exp_q.size());
    cmp_range("R9", "abort after dry queue", 0, exp_q.size() - 1);
    check(ucnt == 1, "R9", "underrun pulse count", ucnt, 1);
  endtask

  task automatic t_gating();
    localparam logic [NSLOT-1:0] GMASK = NSLOT'(1) | (NSLOT'(1) << 3) | (NSLOT'(1) << 10);
    bit prev_en = 1'b0;
    int bad = 0;
    int vcnt = 0;
    apply_reset(1'b0, 1'b0, 1'b0, 8'h00);
    got_q.delete();
    exp_q.delete();
    for (int k = 0; k < 6; k++) push_raw(8'h7E);
    for (int f = 0; f < 2; f++) begin
      for (int p = -1; p < NSLOT * 8; p++) begin
        @(negedge clk);
        if (tx_valid != prev_en) bad++;
        if (tx_valid) begin vcnt++; got_q.push_back(tx_bit); end
        slot_mask = GMASK;
        fbit      = (p < 0);
        slot_idx  = (p < 0) ? SW'(0) : SW'(p / 8);
        prev_en   = !fbit && GMASK[slot_idx];
      end
    end
    @(negedge clk);
    if (tx_valid != prev_en) bad++;
    if (tx_valid) begin vcnt++; got_q.push_back(tx_bit); end
    check(bad == 0, "R1", "tx_valid against enabled positions", bad, 0);
    check(vcnt == 48, "R1", "valid bits over two frames", vcnt, 48);
    cmp_range("R1", "stream continuity across gaps", 0, 47);
    fbit = 1'b0;
    slot_idx = '0;
  endtask

  task automatic t_transparent();
    apply_reset(1'b1, 1'b0, 1'b0, 8'h3C);
    exp_q.delete();
    push_raw(8'hFF); push_raw(8'hFF); push_raw(8'h0F); push_raw(8'h3C); push_raw(8'h3C);
    write_byte(8'hFF, 1'b0);
    write_byte(8'hFF, 1'b1);
    write_byte(8'h0F, 1'b0);
    repeat (4) @(negedge clk);
    slot_mask = '1;
    collect(40);
    cmp_range("R7", "raw bytes then idle", 0, 39);
  endtask

  task automatic t_continuous();
    apply_reset(1'b1, 1'b1, 1'b0, 8'h3C);
    exp_q.delete();
    for (int k = 0; k < 3; k++) begin push_raw(8'h5A); push_raw(8'hC3); end
    write_byte(8'h5A, 1'b0);
    write_byte(8'hC3, 1'b0);
    repeat (4) @(negedge clk);
    slot_mask = '1;
    collect(48);
    cmp_range("R8", "replayed contents", 0, 47);
  endtask

  task automatic t_full();
    apply_reset(1'b1, 1'b0, 1'b0, 8'h3C);
    exp_q.delete();
    for (int i = 0; i < DEPTH; i++) begin
      write_byte(8'(i * 3 + 1), 1'b0);
      push_raw(8'(i * 3 + 1));
    end
    push_raw(8'h3C);
    check(fifo_full == 1'b1, "R6", "full after DEPTH writes", 32'(fifo_full), 1);
    write_byte(8'hEE, 1'b0);
    check(fifo_full == 1'b1, "R6", "full after dropped write", 32'(fifo_full), 1);
    repeat (2) @(negedge clk);
    slot_mask = '1;
    collect(DEPTH * 8 + 8);
    cmp_range("R6", "queued bytes then idle, dropped byte absent", 0, DEPTH * 8 + 7);
    check(fifo_full == 1'b0, "R6", "not full after drain", 32'(fifo_full), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL R1 watchdog: actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_fill(1'b0, 8'h00);
    t_fill(1'b1, 8'hA5);
    t_frame(8'hFF, 8'h7E, 8'h01);
    t_frame(8'hFF, 8'hF8, 8'h1F);
    t_underrun();
    t_gating();
    t_transparent();
    t_continuous();
    t_full();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule